// File: doc/BRIEF.md
# Periodic Interval Timer with Deferred Reload

This block is an 8-bit periodic timer that software programs through a small register port. An interval value `n` is written to a data register, and the timer is started through a control register. From then on the block raises an interval flag once every `n + 1` pulses of a chosen count enable. The count enable is one of three prescaled enables supplied from outside the block, picked by a two-bit source field.

The data register does not feed the comparator directly. A compare latch sits between them. The latch is loaded when the timer starts and again at every match. A new interval written while the timer is running therefore takes effect only after the current period has finished.

A two-state machine (`ST_IDLE`, `ST_RUN`) governs counting:
- Transition **ARM** (`ST_IDLE` to `ST_RUN`) is taken on a control write with the run bit at 1. It clears the counter and loads the latch.
- Transition **HALT** (`ST_RUN` to `ST_IDLE`) is taken on a control write with the run bit at 0. It freezes the counter.
- Any other control write leaves the state as it is.

The interrupt line is the registered AND of the flag and the interrupt enable bit.

Top module: `ivl_timer`

## Requirements
- R1: Source field code 0, 1 or 2 selects `tick_in[code]` as the count enable. Code 3 selects none, so the counter does not move. Pulses on the sources that are not selected have no effect.
- R2: A control write with run=1 while idle (ARM) sets the counter to 0 and copies the data register into the compare latch on that clock edge.
- R3: While running, each selected pulse increments the counter by one when the counter differs from the latch. The counter never exceeds the latch.
- R4: A selected pulse while running with counter equal to latch sets the flag, clears the counter to 0 and reloads the latch from the data register, and counting goes on. The flag therefore rises on the (n+1)-th pulse after ARM. With n=0 it rises on every pulse.
- R5: `irq_o` is low out of reset and, from the clock edge on which the bits change, equals flag AND interrupt enable.
- R6: A control write with flag bit 0 clears the flag. Writing flag bit 1 leaves the flag unchanged. A match in the same cycle as a clearing write leaves the flag at 1.
- R7: A control write with run=0 (HALT) stops counting. The counter holds its value, the latch and the flag are unchanged, and later pulses are ignored.
- R8: A data register write changes only the data register. The latch takes the new value at the next match or the next ARM.
- R9: A control write with run=1 while already running does not restart: the counter and the latch are kept.
- R10: Register map on `bus_addr`: 0 is control, 1 is data, 2 is counter (read only), 3 is latch (read only). Writes to 2 and 3 are ignored. Control bits: bit0 run, bit1 flag, bit2 interrupt enable, bits4:3 source select, bits7:5 read as 0.
- R11: After reset every register reads 0 and the state is `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tick_in | input | 3 | Prescaled count enables, one per source |
| irq_o | output | 1 | Interrupt request |

## Verification
The interval is swept for every usable source over n = 0 to 12 and n = 255. The bench counts selected pulses until the flag rises and compares the count with n+1. Sources that are not selected are pulsed on their own, which separates a correct source decode from one that counts any enable.

Directed sequences then cover the remaining behaviours:
- A data write in mid-period shows the old interval finishing before the new one starts, which tells a latched compare from a direct one.
- A clear written together with a match shows whether a match wins over a clear.
- A HALT followed by pulses, and a run rewrite while running, show whether the counter holds or restarts.
- Source code 3 shows whether the unused code counts.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_DATA  = 2'd1,
        REG_COUNT = 2'd2,
        REG_LATCH = 2'd3
    } reg_addr_e;

    localparam int CTL_RUN    = 0;
    localparam int CTL_FLAG   = 1;
    localparam int CTL_IEN    = 2;
    localparam int CTL_SEL_LO = 3;
endpackage

// File: rtl/ivl_tick_sel.sv
module ivl_tick_sel #(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = tick_i[g] & (sel_i == SEL_W'(g));
    end

    assign tick_o = |hit;

    // R1: codes past the last source never produce a count enable
    assert_unused_code_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) >= NUM_SRC) |-> !tick_o);
endmodule

// File: rtl/ivl_run_fsm.sv
module ivl_run_fsm
    import ivl_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic run_bit_i,
    output logic run_o,
    output logic arm_o
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_wr_i && run_bit_i)  state_d = ST_RUN;   // ARM
            ST_RUN:  if (ctrl_wr_i && !run_bit_i) state_d = ST_IDLE;  // HALT
        endcase
    end

    always_comb begin
        run_o = 1'b0;
        arm_o = 1'b0;
        unique case (state_q)
            ST_IDLE: arm_o = ctrl_wr_i & run_bit_i;
            ST_RUN:  run_o = 1'b1;
        endcase
    end

    // R9: rewriting run=1 while running keeps the state
    assert_stay_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl_wr_i && run_bit_i) |=> (state_q == ST_RUN && !arm_o));
    // R7: HALT always lands in idle
    assert_halt_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && !run_bit_i) |=> !run_o);
endmodule

// File: rtl/ivl_count_core.sv
module ivl_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         arm_i,
    input  logic         tick_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] latch_o,
    output logic         match_o
);
    logic [W-1:0] cnt_q, latch_q;
    logic         step;

    assign step    = run_i & tick_i & ~arm_i;
    assign match_o = step & (cnt_q == latch_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            latch_q <= '0;
        end else if (arm_i || match_o) begin
            cnt_q   <= '0;
            latch_q <= data_i;
        end else if (step) begin
            cnt_q   <= cnt_q + W'(1);
        end
    end

    assign cnt_o   = cnt_q;
    assign latch_o = latch_q;

    // R3: counter stays within the latched bound
    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= latch_q);
    // R4: a match wraps the counter and reloads the latch
    assert_match_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !arm_i && cnt_q == latch_q) |=> (cnt_q == '0 && latch_q == $past(data_i)));
    // R2: arming clears and loads
    assert_arm_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (cnt_q == '0 && latch_q == $past(data_i)));
    // R7: nothing moves while idle
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !arm_i) |=> ($stable(cnt_q) && $stable(latch_q)));
    // R8: latch only changes at arm or match
    assert_latch_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !match_o) |=> $stable(latch_q));
endmodule

// File: rtl/ivl_ctrl_regs.sv
module ivl_ctrl_regs #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic             flag_bit_i,
    input  logic             ien_bit_i,
    input  logic [SEL_W-1:0] sel_bits_i,
    input  logic             match_i,
    output logic             flag_o,
    output logic             ien_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             irq_o
);
    logic             flag_q, flag_d, ien_q, ien_d, irq_q;
    logic [SEL_W-1:0] sel_q, sel_d;

    always_comb begin
        ien_d  = ctrl_wr_i ? ien_bit_i  : ien_q;
        sel_d  = ctrl_wr_i ? sel_bits_i : sel_q;
        flag_d = flag_q;
        if (ctrl_wr_i && !flag_bit_i) flag_d = 1'b0;
        if (match_i)                  flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            sel_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            ien_q  <= ien_d;
            sel_q  <= sel_d;
            irq_q  <= flag_d & ien_d;
        end
    end

    assign flag_o = flag_q;
    assign ien_o  = ien_q;
    assign sel_o  = sel_q;
    assign irq_o  = irq_q;

    // R5: request tracks flag and enable
    assert_irq_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (flag_q & ien_q));
    // R6: match wins over a clear
    assert_match_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> flag_q);
    // R6: a clear without match empties the flag
    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && !flag_bit_i && !match_i) |=> !flag_q);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int W       = 8,
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [W-1:0]       bus_wdata,
    output logic [W-1:0]       bus_rdata,
    input  logic [NUM_SRC-1:0] tick_in,
    output logic               irq_o
);
    localparam int SEL_W = $clog2(NUM_SRC + 1);

    reg_addr_e        addr_e;
    logic             ctrl_wr, run, arm, tick, match, flag, ien;
    logic [SEL_W-1:0] sel;
    logic [W-1:0]     data_q, cnt, latch, ctrl_rd;

    assign addr_e  = reg_addr_e'(bus_addr);
    assign ctrl_wr = bus_we && (addr_e == REG_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           data_q <= '0;
        else if (bus_we && addr_e == REG_DATA) data_q <= bus_wdata;
    end

    ivl_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (ctrl_wr),
        .run_bit_i (bus_wdata[CTL_RUN]),
        .run_o     (run),
        .arm_o     (arm)
    );

    ivl_ctrl_regs #(.SEL_W(SEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (ctrl_wr),
        .flag_bit_i (bus_wdata[CTL_FLAG]),
        .ien_bit_i  (bus_wdata[CTL_IEN]),
        .sel_bits_i (bus_wdata[CTL_SEL_LO +: SEL_W]),
        .match_i    (match),
        .flag_o     (flag),
        .ien_o      (ien),
        .sel_o      (sel),
        .irq_o      (irq_o)
    );

    ivl_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_in),
        .sel_i  (sel),
        .tick_o (tick)
    );

    ivl_count_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .arm_i   (arm),
        .tick_i  (tick),
        .data_i  (data_q),
        .cnt_o   (cnt),
        .latch_o (latch),
        .match_o (match)
    );

    always_comb begin
        ctrl_rd                        = '0;
        ctrl_rd[CTL_RUN]               = run;
        ctrl_rd[CTL_FLAG]              = flag;
        ctrl_rd[CTL_IEN]               = ien;
        ctrl_rd[CTL_SEL_LO +: SEL_W]   = sel;
    end

    always_comb begin
        unique case (addr_e)
            REG_CTRL:  bus_rdata = ctrl_rd;
            REG_DATA:  bus_rdata = data_q;
            REG_COUNT: bus_rdata = cnt;
            REG_LATCH: bus_rdata = latch;
        endcase
    end

    // R8: a data write leaves counter and latch alone unless a match or arm coincides
    assert_data_write_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr_e == REG_DATA && !tick) |=> ($stable(cnt) && $stable(latch)));
    // R10: read-only slots ignore writes
    assert_ro_slots_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (addr_e == REG_COUNT || addr_e == REG_LATCH)) |=> $stable(data_q));
endmodule

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [2:0] tick_in = 3'd0;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ivl_timer u_ivl_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] ctl(input int run, input int flg, input int ien, input int sel);
        return 8'(run | (flg << 1) | (ien << 2) | (sel << 3));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tk(input logic [2:0] m);
        tick_in = m;
        @(negedge clk);
        tick_in = 3'd0;
    endtask

    task automatic flag_now(output int f);
        int v;
        rd(2'd0, v);
        f = (v >> 1) & 1;
    endtask

    task automatic run_interval(input int s, input int n);
        int v, f;
        wr(2'd0, ctl(0, 0, 0, s));
        wr(2'd1, 8'(n));
        wr(2'd0, ctl(1, 0, 0, s));
        rd(2'd2, v); chk("R2 count after arm", v, 0);
        rd(2'd3, v); chk("R2 latch after arm", v, n);
        tk(3'b111 & ~(3'd1 << s));
        rd(2'd2, v); chk("R1 unselected source ignored", v, 0);
        for (int k = 1; k <= n + 1; k++) begin
            tk(3'd1 << s);
            rd(2'd2, v); flag_now(f);
            if (k <= n) begin
                chk("R3 count step", v, k);
                chk("R4 no early flag", f, 0);
            end else begin
                chk("R4 flag at n+1", f, 1);
                chk("R4 counter wraps", v, 0);
                rd(2'd3, v); chk("R4 latch reloaded", v, n);
            end
        end
    endtask

    initial begin
        int v, f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R11 reset register", v, 0);
        end
        chk("R11 irq low", int'(irq_o), 0);

        for (int s = 0; s < 3; s++)
            for (int n = 0; n <= 12; n++)
                run_interval(s, n);
        run_interval(0, 255);

        // R5 interrupt
        wr(2'd0, ctl(0, 0, 0, 0));
        wr(2'd1, 8'd2);
        wr(2'd0, ctl(1, 0, 1, 0));
        repeat (3) tk(3'b001);
        chk("R5 irq with enable", int'(irq_o), 1);
        wr(2'd0, ctl(1, 1, 0, 0));
        chk("R5 irq off with enable 0", int'(irq_o), 0);
        flag_now(f); chk("R6 write 1 keeps flag", f, 1);
        wr(2'd0, ctl(1, 1, 1, 0));
        chk("R5 irq back on", int'(irq_o), 1);
        wr(2'd0, ctl(1, 0, 1, 0));
        flag_now(f); chk("R6 clear flag", f, 0);
        chk("R5 irq after clear", int'(irq_o), 0);
        wr(2'd0, ctl(1, 1, 0, 0));
        flag_now(f); chk("R6 write 1 on clear flag", f, 0);

        // R9 no restart
        tk(3'b001);
        wr(2'd0, ctl(1, 0, 0, 0));
        rd(2'd2, v); chk("R9 counter kept", v, 1);

        // R8 deferred reload
        wr(2'd1, 8'd6);
        rd(2'd3, v); chk("R8 latch keeps old interval", v, 2);
        rd(2'd1, v); chk("R8 data written", v, 6);
        tk(3'b001); tk(3'b001);
        flag_now(f); chk("R8 old interval ends", f, 1);
        rd(2'd3, v); chk("R8 latch picks new value", v, 6);
        wr(2'd0, ctl(1, 0, 0, 0));
        repeat (6) tk(3'b001);
        flag_now(f); chk("R8 no flag before 7", f, 0);
        tk(3'b001);
        flag_now(f); chk("R8 flag at 7", f, 1);

        // R6 match and clear together
        wr(2'd0, ctl(1, 0, 0, 0));
        repeat (6) tk(3'b001);
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = ctl(1, 0, 0, 0); tick_in = 3'b001;
        @(negedge clk);
        bus_we = 1'b0; tick_in = 3'd0;
        flag_now(f); chk("R6 match beats clear", f, 1);

        // R7 halt
        wr(2'd0, ctl(1, 0, 0, 0));
        repeat (3) tk(3'b001);
        wr(2'd1, 8'd9);
        wr(2'd0, ctl(0, 1, 0, 0));
        repeat (4) tk(3'b111);
        rd(2'd2, v); chk("R7 counter held", v, 3);
        rd(2'd3, v); chk("R7 latch held", v, 6);
        flag_now(f); chk("R7 flag unchanged", f, 0);

        // R2 re-arm
        wr(2'd0, ctl(1, 0, 0, 0));
        rd(2'd2, v); chk("R2 re-arm clears", v, 0);
        rd(2'd3, v); chk("R2 re-arm loads", v, 9);

        // R1 unused code
        wr(2'd0, ctl(0, 0, 0, 0));
        wr(2'd0, ctl(1, 0, 0, 3));
        repeat (5) tk(3'b111);
        rd(2'd2, v); chk("R1 code 3 does not count", v, 0);

        // R10 map
        rd(2'd0, v); chk("R10 control readback", v, 8'h19);
        wr(2'd2, 8'd55);
        wr(2'd3, 8'd55);
        rd(2'd2, v); chk("R10 counter write ignored", v, 0);
        rd(2'd3, v); chk("R10 latch write ignored", v, 9);
        rd(2'd1, v); chk("R10 data unchanged", v, 9);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule